// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves control transfers for a simple load-store processor with fixed 4-byte instructions. For each operation it receives the operation code, two register operands, the current program counter, a 16-bit branch offset field, a 26-bit absolute target field and an indirect target value. It decides whether the transfer is taken and computes the next program counter. For calls it also produces a link address.

The same unit also evaluates set-less-than operations, signed or unsigned, against either a second register or the sign-extended offset field. The result is a full-width word holding 1 or 0. Branches against zero use only the operand's sign bit and a zero detect; they need no subtraction.

All results are registered. They appear one clock after the request is accepted on `op_valid`. The unit does not perform fetch, prediction or delay-slot handling.

Top module: `br_next_pc_unit`

## Requirements
- R1: On a synchronous active-high reset, `res_valid`, `taken`, `next_pc`, `link_addr` and `slt_word` all become 0.
- R2: A request with `op_valid` high produces its results and `res_valid` high on the following clock edge. While `op_valid` is low, `res_valid` is 0 and every other output keeps its value.
- R3: Operation codes on `op_code` are: 0 sequential, 1 branch-equal, 2 branch-not-equal, 3 branch if greater than zero, 4 branch if greater or equal to zero, 5 branch if less than zero, 6 branch if less or equal to zero, 7 jump, 8 call, 9 indirect jump, 10 indirect call, 11 set-less-than signed, 12 set-less-than unsigned, 13 set-less-than-immediate signed, 14 set-less-than-immediate unsigned. Code 1 is taken when `rs_val` equals `rt_val`; code 2 is taken when they differ.
- R4: Codes 3 to 6 compare `rs_val`, read as two's complement, against zero. `rt_val` has no effect on them.
- R5: A taken conditional branch goes to PC+4 plus the sign-extended offset shifted left by 2. A not-taken one goes to PC+4. All additions wrap modulo 2^XLEN.
- R6: Codes 7 and 8 are always taken. Their target is the top XLEN-28 bits of PC+4, then the 26-bit field, then two zero bits.
- R7: Codes 9 and 10 are always taken, with `ind_target` as the next PC.
- R8: Codes 8 and 10 set `link_addr` to PC+4. Every other code sets it to 0.
- R9: Codes 11 and 12 set `slt_word` to 1 when `rs_val` < `rt_val`, compared signed or unsigned respectively, and to 0 otherwise. They are not taken and go to PC+4.
- R10: Codes 13 and 14 compare `rs_val` with the sign-extended `br_offset`. Code 14 compares both as unsigned after the extension.
- R11: Code 0, code 15 and all branch or jump codes give `slt_word` 0. Codes 0 and 15 are not taken and go to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code (see R3) |
| rs_val | input | XLEN | First register operand |
| rt_val | input | XLEN | Second register operand |
| pc_in | input | XLEN | Address of the current instruction |
| br_offset | input | 16 | Branch offset / immediate field |
| jmp_field | input | 26 | Absolute target field |
| ind_target | input | XLEN | Indirect target register value |
| res_valid | output | 1 | Results valid |
| taken | output | 1 | Transfer taken |
| next_pc | output | XLEN | Next program counter |
| link_addr | output | XLEN | Return address for calls, else 0 |
| slt_word | output | XLEN | Set-less-than result (1 or 0) |

## Verification
Assertions check several properties on every cycle:
- the one-cycle latency of `res_valid`;
- that a not-taken result always points to PC+4;
- that jumps and calls are always taken;
- that `link_addr` is zero outside calls;
- that `slt_word` never holds anything but 0 or 1.

The bench's scenarios carry the rest. They cover the exact arithmetic of relative and absolute targets, including negative offsets and address wrap. They also cover signed and unsigned orderings at the sign boundary, the zero tests at −1, 0 and +1, and the fact that outputs hold while no request arrives.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [3:0] {
    OP_SEQ    = 4'd0,
    OP_BEQ    = 4'd1,
    OP_BNE    = 4'd2,
    OP_BGTZ   = 4'd3,
    OP_BGEZ   = 4'd4,
    OP_BLTZ   = 4'd5,
    OP_BLEZ   = 4'd6,
    OP_JMP    = 4'd7,
    OP_CALL   = 4'd8,
    OP_JIND   = 4'd9,
    OP_CIND   = 4'd10,
    OP_SLT    = 4'd11,
    OP_SLTU   = 4'd12,
    OP_SLTI   = 4'd13,
    OP_SLTIU  = 4'd14,
    OP_RSV    = 4'd15
  } br_op_e;

  function automatic logic is_cond(br_op_e op);
    return (op >= OP_BEQ) && (op <= OP_BLEZ);
  endfunction
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_op_e            op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic              hit
);
  logic a_zero, a_neg, same;

  // zero tests need only a sign bit and a NOR tree
  assign a_zero = ~|a;
  assign a_neg  = a[XLEN-1];
  assign same   = (a == b);

  always_comb begin
    unique case (op)
      OP_BEQ:  hit = same;
      OP_BNE:  hit = ~same;
      OP_BGTZ: hit = ~a_neg & ~a_zero;
      OP_BGEZ: hit = ~a_neg;
      OP_BLTZ: hit = a_neg;
      OP_BLEZ: hit = a_neg | a_zero;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26,
  parameter int ISIZE = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic [JT_W-1:0]  jfield,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  rel_pc,
  output logic [XLEN-1:0]  abs_pc
);
  localparam int SH   = $clog2(ISIZE);
  localparam int EXT  = XLEN - OFF_W - SH;
  localparam int HI_W = XLEN - JT_W - SH;

  logic [XLEN-1:0] disp;

  assign seq_pc = pc + XLEN'(ISIZE);
  assign disp   = {{EXT{off[OFF_W-1]}}, off, {SH{1'b0}}};
  assign rel_pc = seq_pc + disp;

  generate
    if (HI_W > 0) begin : g_region
      assign abs_pc = {seq_pc[XLEN-1 -: HI_W], jfield, {SH{1'b0}}};
    end else begin : g_flat
      assign abs_pc = XLEN'({jfield, {SH{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/br_slt_cmp.sv
module br_slt_cmp
  import br_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  br_op_e            op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic [OFF_W-1:0]  imm,
  output logic              lt
);
  localparam int EXT = XLEN - OFF_W;

  logic [XLEN-1:0] rhs;
  logic            use_imm, unsig;
  logic [XLEN:0]   diff;

  assign use_imm = (op == OP_SLTI) || (op == OP_SLTIU);
  assign unsig   = (op == OP_SLTU) || (op == OP_SLTIU);
  assign rhs     = use_imm ? {{EXT{imm[OFF_W-1]}}, imm} : b;

  // one subtractor; signedness handled by flipping sign bits
  always_comb begin
    logic [XLEN-1:0] l, r;
    l = a;
    r = rhs;
    if (!unsig) begin
      l[XLEN-1] = ~a[XLEN-1];
      r[XLEN-1] = ~rhs[XLEN-1];
    end
    diff = {1'b0, l} - {1'b0, r};
    lt   = (op == OP_SLT || op == OP_SLTU || op == OP_SLTI || op == OP_SLTIU)
           ? diff[XLEN] : 1'b0;
  end
endmodule

// File: rtl/br_next_pc_unit.sv
module br_next_pc_unit
  import br_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [OFF_W-1:0] br_offset,
  input  logic [JT_W-1:0]  jmp_field,
  input  logic [XLEN-1:0]  ind_target,
  output logic             res_valid,
  output logic             taken,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  link_addr,
  output logic [XLEN-1:0]  slt_word
);
  br_op_e          op;
  logic            hit, lt;
  logic [XLEN-1:0] seq_pc, rel_pc, abs_pc;
  logic            take_d;
  logic [XLEN-1:0] npc_d, link_d;

  assign op = br_op_e'(op_code);

  br_cond_eval #(.XLEN(XLEN)) u_cond (
    .op(op), .a(rs_val), .b(rt_val), .hit(hit));

  br_target_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W), .ISIZE(4)) u_tgt (
    .pc(pc_in), .off(br_offset), .jfield(jmp_field),
    .seq_pc(seq_pc), .rel_pc(rel_pc), .abs_pc(abs_pc));

  br_slt_cmp #(.XLEN(XLEN), .OFF_W(OFF_W)) u_slt (
    .op(op), .a(rs_val), .b(rt_val), .imm(br_offset), .lt(lt));

  always_comb begin
    take_d = 1'b0;
    npc_d  = seq_pc;
    link_d = '0;
    if (is_cond(op)) begin
      take_d = hit;
      npc_d  = hit ? rel_pc : seq_pc;
    end else begin
      unique case (op)
        OP_JMP:  begin take_d = 1'b1; npc_d = abs_pc; end
        OP_CALL: begin take_d = 1'b1; npc_d = abs_pc; link_d = seq_pc; end
        OP_JIND: begin take_d = 1'b1; npc_d = ind_target; end
        OP_CIND: begin take_d = 1'b1; npc_d = ind_target; link_d = seq_pc; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      link_addr <= '0;
      slt_word  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        taken     <= take_d;
        next_pc   <= npc_d;
        link_addr <= link_d;
        slt_word  <= XLEN'(lt);
      end
    end
  end

  // R2: result strobe follows the request by exactly one cycle
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R5: a not-taken result always points to the next sequential word
  a_r5_fallthrough: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (taken || next_pc == $past(pc_in) + XLEN'(4)));

  // R6: jumps and calls never fall through
  a_r6_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd7 || op_code == 4'd8)) |=> taken);

  // R8: link value only for calls
  a_r8_link_zero: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code != 4'd8 && op_code != 4'd10) |=> (link_addr == '0));

  // R9: comparison result is a single bit wide
  a_r9_slt_binary: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (slt_word[XLEN-1:1] == '0));
endmodule

// File: tb/tb_br_next_pc_unit.sv
module tb_br_next_pc_unit;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst = 1'b1, op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] rs_val = '0, rt_val = '0, pc_in = '0, ind_target = '0;
  logic [15:0] br_offset = '0;
  logic [25:0] jmp_field = '0;
  logic        res_valid, taken;
  logic [31:0] next_pc, link_addr, slt_word;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  br_next_pc_unit #(.XLEN(XLEN), .OFF_W(16), .JT_W(26)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .rs_val(rs_val), .rt_val(rt_val), .pc_in(pc_in), .br_offset(br_offset),
    .jmp_field(jmp_field), .ind_target(ind_target), .res_valid(res_valid),
    .taken(taken), .next_pc(next_pc), .link_addr(link_addr), .slt_word(slt_word));

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] rel(logic [31:0] pc, logic [15:0] off);
    return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic run(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                     logic [31:0] pc, logic [15:0] off, logic [25:0] jf, logic [31:0] ind,
                     logic e_tk, logic [31:0] e_npc, logic [31:0] e_lnk, logic [31:0] e_slt);
    @(negedge clk);
    op_valid = 1; op_code = op; rs_val = a; rt_val = b; pc_in = pc;
    br_offset = off; jmp_field = jf; ind_target = ind;
    @(negedge clk);
    op_valid = 0;
    chk(req, "valid", {31'd0, res_valid}, 32'd1);
    chk(req, "taken", {31'd0, taken}, {31'd0, e_tk});
    chk(req, "next_pc", next_pc, e_npc);
    chk(req, "link", link_addr, e_lnk);
    chk(req, "slt", slt_word, e_slt);
  endtask

  task automatic t_reset;
    chk("R1", "valid", {31'd0, res_valid}, 0);
    chk("R1", "taken", {31'd0, taken}, 0);
    chk("R1", "next_pc", next_pc, 0);
    chk("R1", "link", link_addr, 0);
    chk("R1", "slt", slt_word, 0);
  endtask

  task automatic t_equality; // R3
    run("R3", 4'd1, 32'h55, 32'h55, 32'h100, 16'hFFFC, 0, 0, 1, rel(32'h100, 16'hFFFC), 0, 0);
    run("R3", 4'd1, 32'h55, 32'h56, 32'h100, 16'h0010, 0, 0, 0, 32'h104, 0, 0);
    run("R3", 4'd2, 32'h1, 32'h2, 32'h200, 16'h0008, 0, 0, 1, 32'h200 + 4 + 32, 0, 0);
    run("R3", 4'd2, 32'h7, 32'h7, 32'h200, 16'h0008, 0, 0, 0, 32'h204, 0, 0);
  endtask

  task automatic t_zero; // R4, rt_val set to mislead
    run("R4", 4'd3, 32'd1, 32'd9, 32'h40, 16'd2, 0, 0, 1, 32'h4C, 0, 0);
    run("R4", 4'd3, 32'd0, 32'd9, 32'h40, 16'd2, 0, 0, 0, 32'h44, 0, 0);
    run("R4", 4'd4, 32'd0, 32'hF, 32'h40, 16'd2, 0, 0, 1, 32'h4C, 0, 0);
    run("R4", 4'd4, 32'hFFFFFFFF, 32'd0, 32'h40, 16'd2, 0, 0, 0, 32'h44, 0, 0);
    run("R4", 4'd5, 32'h80000000, 32'd0, 32'h40, 16'd2, 0, 0, 1, 32'h4C, 0, 0);
    run("R4", 4'd5, 32'd0, 32'hFFFFFFFF, 32'h40, 16'd2, 0, 0, 0, 32'h44, 0, 0);
    run("R4", 4'd6, 32'd0, 32'd5, 32'h40, 16'd2, 0, 0, 1, 32'h4C, 0, 0);
    run("R4", 4'd6, 32'd1, 32'd5, 32'h40, 16'd2, 0, 0, 0, 32'h44, 0, 0);
  endtask

  task automatic t_wrap; // R5
    run("R5", 4'd1, 0, 0, 32'hFFFFFFF8, 16'h0004, 0, 0, 1, 32'h0000000C, 0, 0);
    run("R5", 4'd0, 0, 0, 32'hFFFFFFFC, 16'h0000, 0, 0, 0, 32'h00000000, 0, 0);
    run("R5", 4'd1, 0, 0, 32'h00000010, 16'h8000, 0, 0, 1, rel(32'h10, 16'h8000), 0, 0);
  endtask

  task automatic t_abs; // R6, R8
    run("R6", 4'd7, 0, 0, 32'hA0001230, 0, 26'h3ABCDEF, 0, 1, {4'hA, 26'h3ABCDEF, 2'b00}, 0, 0);
    run("R6", 4'd7, 0, 0, 32'h3FFFFFFC, 0, 26'h1, 0, 1, {4'h4, 26'h1, 2'b00}, 0, 0);
    run("R8", 4'd8, 0, 0, 32'h5000_0100, 0, 26'h10, 0, 1, {4'h5, 26'h10, 2'b00}, 32'h5000_0104, 0);
  endtask

  task automatic t_ind; // R7, R8
    run("R7", 4'd9, 0, 0, 32'h800, 0, 0, 32'hDEAD_BEE0, 1, 32'hDEAD_BEE0, 0, 0);
    run("R8", 4'd10, 0, 0, 32'h900, 0, 0, 32'h1234_5678, 1, 32'h1234_5678, 32'h904, 0);
  endtask

  task automatic t_slt; // R9, R10
    run("R9", 4'd11, 32'hFFFFFFFF, 32'd1, 32'h10, 16'h7, 0, 0, 0, 32'h14, 0, 1);
    run("R9", 4'd12, 32'hFFFFFFFF, 32'd1, 32'h10, 16'h7, 0, 0, 0, 32'h14, 0, 0);
    run("R9", 4'd11, 32'd3, 32'd3, 32'h10, 0, 0, 0, 0, 32'h14, 0, 0);
    run("R9", 4'd12, 32'd2, 32'h80000000, 32'h10, 0, 0, 0, 0, 32'h14, 0, 1);
    run("R10", 4'd13, 32'hFFFFFFFE, 32'd0, 32'h10, 16'hFFFF, 0, 0, 0, 32'h14, 0, 1);
    run("R10", 4'd13, 32'd5, 32'd0, 32'h10, 16'hFFFF, 0, 0, 0, 32'h14, 0, 0);
    run("R10", 4'd14, 32'd5, 32'd0, 32'h10, 16'hFFFF, 0, 0, 0, 32'h14, 0, 1);
    run("R10", 4'd14, 32'd5, 32'd0, 32'h10, 16'h0005, 0, 0, 0, 32'h14, 0, 0);
  endtask

  task automatic t_other; // R11
    run("R11", 4'd15, 32'd0, 32'd1, 32'h300, 16'h10, 26'h5, 32'h777, 0, 32'h304, 0, 0);
    run("R11", 4'd0, 32'd0, 32'd1, 32'h300, 16'h10, 26'h5, 32'h777, 0, 32'h304, 0, 0);
    run("R11", 4'd5, 32'hFFFFFFFF, 32'd1, 32'h300, 16'h1, 0, 0, 1, 32'h308, 0, 0);
  endtask

  task automatic t_hold; // R2
    run("R2", 4'd9, 0, 0, 32'h40, 0, 0, 32'hCAFE0000, 1, 32'hCAFE0000, 0, 0);
    @(negedge clk);
    op_code = 4'd0; pc_in = 32'h1000; rs_val = 32'h5;
    @(negedge clk);
    chk("R2", "valid idle", {31'd0, res_valid}, 0);
    chk("R2", "next_pc held", next_pc, 32'hCAFE0000);
    chk("R2", "taken held", {31'd0, taken}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_equality();
    t_zero();
    t_wrap();
    t_abs();
    t_ind();
    t_slt();
    t_other();
    t_hold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule